// File: doc/BRIEF.md
# Power-Management Event Register Block

This block is a small bank of power-management registers reached through a 16-bit write port and a combinational read port. The bank has three registers: an event status register, an event enable register and a sleep control register. Only the low six bits of the incoming address select a register. Status bits are set by hardware and cleared by software. The block raises a level interrupt whenever a status bit is set and its enable bit is also set.

A free-running timer counts every clock. When the count reaches a programmable overflow deadline, the timer sets the overflow status bit. Clearing that bit moves the deadline forward to the next aligned boundary.

A write to the control register with the sleep-enable bit set starts a sleep action. Sleep type 0 issues a power-off request. Sleep type 1 is treated as a suspend that comes back through a reset. It marks a power-button wake, requests a reset and raises a resume indication for the reset handler.

Top module: `pmevt_block`

## Requirements
- R1: The register offset is `addr[5:0]`: status at 0x00, enable at 0x02, control at 0x04. Reads of any other offset return 0. Writes to any other offset change no register.
- R2: After reset, status, enable and control all read 0. The outputs `sci_irq`, `off_req`, `rst_req` and `resume_ind` are all low.
- R3: Writing the status register clears each bit written as 1. Bits written as 0 keep their value. A hardware set in the same cycle wins over the clear.
- R4: The enable register stores and reads back all 16 written bits.
- R5: A control write stores the written value with bit 13 (sleep enable) forced to 0, so bit 13 always reads 0.
- R6: A control write with bit 13 set and `wdata[12:10]` = 0 gives `off_req` high for exactly the one cycle after the write edge.
- R7: A control write with bit 13 set and `wdata[12:10]` = 1 has these effects:
  - it sets status bit 15 (wake) and status bit 8 (power button);
  - it gives `rst_req` high for exactly one cycle after the write edge;
  - it raises `resume_ind`, which then stays high until reset.
- R8: A control write with bit 13 clear, or with sleep type 2 to 7, raises neither request.
- R9: `sci_irq` is high exactly when status AND enable is nonzero. It follows every status or enable change.
- R10: The timer is TMR_W bits wide, starts at 0 after reset and counts up by one each clock. Status bit 0 (timer overflow) is set on the edge after the count equals the deadline. The deadline is 2^STEP_LOG2 after reset.
- R11: A status write that clears status bit 0 while it is set moves the deadline. The new deadline is (count at that write edge + 2^STEP_LOG2) with its low STEP_LOG2 bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address; only the low 6 bits are decoded |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| sci_irq | output | 1 | Level interrupt: enabled status pending |
| off_req | output | 1 | One-cycle power-off request |
| rst_req | output | 1 | One-cycle reset request from a suspend |
| resume_ind | output | 1 | Resume-from-suspend indication, held until reset |

## Verification
The bench builds the block with a 12-bit timer and STEP_LOG2 = 9, so the first deadline falls at count 512 instead of 2^23. With these values the first overflow and two re-armed deadlines (1024 and 1536) fall within under two thousand cycles. The re-arm points are chosen so that a deadline computed without the alignment mask would land on a different cycle. ADDR_W stays at 16, so writes with nonzero upper address bits check that only the low six bits are decoded.

// File: rtl/pmevt_pkg.sv
package pmevt_pkg;
   // offset field decoded from the incoming address
   localparam int unsigned OFF_W = 6;
   localparam logic [OFF_W-1:0] OFF_STS = 6'h00;
   localparam logic [OFF_W-1:0] OFF_EN  = 6'h02;
   localparam logic [OFF_W-1:0] OFF_CTL = 6'h04;

   // bit positions other logic depends on
   localparam int unsigned BIT_TMR    = 0;
   localparam int unsigned BIT_PWRBTN = 8;
   localparam int unsigned BIT_WAKE   = 15;
   localparam int unsigned BIT_SLPEN  = 13;
   localparam int unsigned SLPTYP_LO  = 10;
   localparam int unsigned SLPTYP_W   = 3;
   localparam int unsigned MIN_DATA_W = 16;

   localparam logic [SLPTYP_W-1:0] SLP_POWEROFF = 3'd0;
   localparam logic [SLPTYP_W-1:0] SLP_SUSPEND  = 3'd1;

   typedef struct packed {
      logic sts;
      logic en;
      logic ctl;
   } sel_t;
endpackage

// File: rtl/pmevt_decode.sv
module pmevt_decode
   import pmevt_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output sel_t              rd_sel,
   output sel_t              wr_sel
);
   logic [OFF_W-1:0] off;
   assign off = addr[OFF_W-1:0];

   generate
      if (ADDR_W > OFF_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:OFF_W];
      end
   endgenerate

   always_comb begin
      rd_sel.sts = (off == OFF_STS);
      rd_sel.en  = (off == OFF_EN);
      rd_sel.ctl = (off == OFF_CTL);
      wr_sel     = wr_en ? rd_sel : '0;
   end
endmodule

// File: rtl/pmevt_timer.sv
module pmevt_timer #(
   parameter int unsigned TMR_W     = 24,
   parameter int unsigned STEP_LOG2 = 23
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rearm,
   output logic hit
);
   localparam logic [TMR_W-1:0] STEP     = {{(TMR_W-1){1'b0}}, 1'b1} << STEP_LOG2;
   localparam logic [TMR_W-1:0] LOW_MASK = STEP - 1'b1;

   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] dl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dl_q  <= STEP;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (rearm) dl_q <= (cnt_q + STEP) & ~LOW_MASK;
      end
   end

   assign hit = (cnt_q == dl_q);
endmodule

// File: rtl/pmevt_sleep.sv
module pmevt_sleep
   import pmevt_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              wake_set,
   output logic              off_req,
   output logic              rst_req,
   output logic              resume_ind
);
   logic                slp_go;
   logic [SLPTYP_W-1:0] typ;
   logic                do_off;
   logic                unused_bits;

   assign slp_go      = ctl_wr && wdata[BIT_SLPEN];
   assign typ         = wdata[SLPTYP_LO +: SLPTYP_W];
   assign do_off      = slp_go && (typ == SLP_POWEROFF);
   assign wake_set    = slp_go && (typ == SLP_SUSPEND);
   assign unused_bits = ^{wdata[DATA_W-1:BIT_SLPEN+1], wdata[SLPTYP_LO-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_req    <= 1'b0;
         rst_req    <= 1'b0;
         resume_ind <= 1'b0;
      end else begin
         off_req    <= do_off;
         rst_req    <= wake_set;
         resume_ind <= resume_ind | wake_set;
      end
   end
endmodule

// File: rtl/pmevt_regs.sv
module pmevt_regs
   import pmevt_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sel_t              rd_sel,
   input  sel_t              wr_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tmr_hit,
   input  logic              wake_set,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] enable_q,
   output logic [DATA_W-1:0] control_q,
   output logic [DATA_W-1:0] rdata,
   output logic              tmr_rearm
);
   localparam logic [DATA_W-1:0] SLPEN_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << BIT_SLPEN;

   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] sts_d;

   always_comb begin
      set_vec             = '0;
      set_vec[BIT_TMR]    = tmr_hit;
      set_vec[BIT_PWRBTN] = wake_set;
      set_vec[BIT_WAKE]   = wake_set;
   end

   // only bits with a hardware source get storage; a set beats a clear
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_sts
         if (i == BIT_TMR || i == BIT_PWRBTN || i == BIT_WAKE) begin : g_impl
            assign sts_d[i] = set_vec[i] | (status_q[i] & ~(wr_sel.sts & wdata[i]));
         end else begin : g_rsvd
            assign sts_d[i] = 1'b0;
         end
      end
   endgenerate

   assign tmr_rearm = wr_sel.sts && wdata[BIT_TMR] && status_q[BIT_TMR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q  <= '0;
         enable_q  <= '0;
         control_q <= '0;
      end else begin
         status_q <= sts_d;
         if (wr_sel.en)  enable_q  <= wdata;
         if (wr_sel.ctl) control_q <= wdata & ~SLPEN_MASK;
      end
   end

   always_comb begin
      if (rd_sel.sts)      rdata = status_q;
      else if (rd_sel.en)  rdata = enable_q;
      else if (rd_sel.ctl) rdata = control_q;
      else                 rdata = '0;
   end
endmodule

// File: rtl/pmevt_block.sv
module pmevt_block
   import pmevt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned TMR_W     = 24,
   parameter int unsigned STEP_LOG2 = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              sci_irq,
   output logic              off_req,
   output logic              rst_req,
   output logic              resume_ind
);
   generate
      if (ADDR_W < OFF_W) begin : g_bad_addr
         $error("pmevt_block: ADDR_W must cover the offset field");
      end
      if (DATA_W < MIN_DATA_W) begin : g_bad_data
         $error("pmevt_block: DATA_W too narrow for the status bits");
      end
      if (STEP_LOG2 >= TMR_W) begin : g_bad_tmr
         $error("pmevt_block: STEP_LOG2 must be below TMR_W");
      end
   endgenerate

   sel_t              rd_sel;
   sel_t              wr_sel;
   logic              tmr_hit;
   logic              tmr_rearm;
   logic              wake_set;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] enable_q;
   logic [DATA_W-1:0] control_q;

   pmevt_decode #(.ADDR_W(ADDR_W)) i_decode (
      .wr_en (wr_en),
      .addr  (addr),
      .rd_sel(rd_sel),
      .wr_sel(wr_sel)
   );

   pmevt_timer #(.TMR_W(TMR_W), .STEP_LOG2(STEP_LOG2)) i_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .rearm(tmr_rearm),
      .hit  (tmr_hit)
   );

   pmevt_sleep #(.DATA_W(DATA_W)) i_sleep (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (wr_sel.ctl),
      .wdata     (wdata),
      .wake_set  (wake_set),
      .off_req   (off_req),
      .rst_req   (rst_req),
      .resume_ind(resume_ind)
   );

   pmevt_regs #(.DATA_W(DATA_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_sel   (rd_sel),
      .wr_sel   (wr_sel),
      .wdata    (wdata),
      .tmr_hit  (tmr_hit),
      .wake_set (wake_set),
      .status_q (status_q),
      .enable_q (enable_q),
      .control_q(control_q),
      .rdata    (rdata),
      .tmr_rearm(tmr_rearm)
   );

   assign sci_irq = |(status_q & enable_q);
endmodule

// File: rtl/pmevt_chk.sv
module pmevt_chk
   import pmevt_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              sci_irq,
   input logic              off_req,
   input logic              rst_req,
   input logic              resume_ind,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] enable_q,
   input logic [DATA_W-1:0] control_q,
   input logic              tmr_hit
);
   logic [OFF_W-1:0] off;
   logic             unmapped;
   assign off      = addr[OFF_W-1:0];
   assign unmapped = (off != OFF_STS) && (off != OFF_EN) && (off != OFF_CTL);

   p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && unmapped) |=> ($stable(enable_q) && $stable(control_q)));

   p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_STS && wdata[BIT_PWRBTN]) |=> !status_q[BIT_PWRBTN]);

   p_slpen_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (off == OFF_CTL) |-> !rdata[BIT_SLPEN]);

   p_off_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      off_req |=> !off_req);

   p_off_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      off_req |-> $past(wr_en && off == OFF_CTL && wdata[BIT_SLPEN]
                        && wdata[SLPTYP_LO +: SLPTYP_W] == SLP_POWEROFF));

   p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_rst_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (resume_ind && status_q[BIT_WAKE] && status_q[BIT_PWRBTN]));

   p_resume_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resume_ind |=> resume_ind);

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(off_req && rst_req));

   p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_EN && wdata == '0) |=> !sci_irq);

   p_ovf_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[BIT_TMR]) |-> $past(tmr_hit));
endmodule

bind pmevt_block pmevt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .rdata     (rdata),
   .sci_irq   (sci_irq),
   .off_req   (off_req),
   .rst_req   (rst_req),
   .resume_ind(resume_ind),
   .status_q  (status_q),
   .enable_q  (enable_q),
   .control_q (control_q),
   .tmr_hit   (tmr_hit)
);

// File: tb/test_pmevt_block.sv
module test_pmevt_block;
   localparam int unsigned ADDR_W    = 16;
   localparam int unsigned DATA_W    = 16;
   localparam int unsigned TMR_W     = 12;
   localparam int unsigned STEP_LOG2 = 9;
   localparam int          STEP      = 1 << STEP_LOG2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              sci_irq, off_req, rst_req, resume_ind;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   pmevt_block #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W), .STEP_LOG2(STEP_LOG2))
   i_pmevt_block (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .sci_irq(sci_irq), .off_req(off_req), .rst_req(rst_req),
      .resume_ind(resume_ind)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_cyc(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [DATA_W-1:0] v;
      rd(16'h0000, v); chk("R2 status", v, 0);
      rd(16'h0002, v); chk("R2 enable", v, 0);
      rd(16'h0004, v); chk("R2 control", v, 0);
      chk("R2 outputs", {sci_irq, off_req, rst_req, resume_ind}, 0);
   endtask

   task automatic t_decode;
      logic [DATA_W-1:0] v;
      wr(16'hFF42, 16'hA5A5);
      rd(16'h0002, v); chk("R1 R4 enable via upper addr bits", v, 16'hA5A5);
      wr(16'h0006, 16'hFFFF);
      wr(16'h003E, 16'hFFFF);
      rd(16'h0002, v); chk("R1 unmapped write leaves enable", v, 16'hA5A5);
      rd(16'h0004, v); chk("R1 unmapped write leaves control", v, 0);
      rd(16'h0006, v); chk("R1 unmapped read", v, 0);
      wr(16'h0002, 16'h5A3C);
      rd(16'h0002, v); chk("R4 enable pattern", v, 16'h5A3C);
      wr(16'h0002, 16'h0000);
      rd(16'h0002, v); chk("R4 enable zero", v, 0);
   endtask

   task automatic t_control;
      logic [DATA_W-1:0] v;
      wr(16'h0004, 16'h3D23);
      chk("R8 type 7 no request", {off_req, rst_req}, 0);
      rd(16'h0004, v); chk("R5 control bit13 dropped", v, 16'h1D23);
      @(negedge clk);
      chk("R8 type 7 still quiet", {off_req, rst_req}, 0);
      wr(16'h0004, 16'h0400);
      chk("R8 no sleep enable no request", {off_req, rst_req, resume_ind}, 0);
      rd(16'h0004, v); chk("R5 control stores type", v, 16'h0400);
      rd(16'h0000, v); chk("R8 status untouched", v, 0);
   endtask

   task automatic t_poweroff;
      logic [DATA_W-1:0] v;
      wr(16'h0004, 16'h2000);
      chk("R6 off_req pulse", {off_req, rst_req}, 2'b10);
      rd(16'h0004, v); chk("R5 control after poweroff", v, 0);
      @(negedge clk);
      chk("R6 off_req one cycle", off_req, 0);
      rd(16'h0000, v); chk("R6 status untouched", v, 0);
   endtask

   task automatic t_suspend;
      logic [DATA_W-1:0] v;
      wr(16'h0004, 16'h2400);
      chk("R7 rst_req pulse", {off_req, rst_req, resume_ind}, 3'b011);
      rd(16'h0000, v); chk("R7 wake and button status", v, 16'h8100);
      chk("R9 irq masked", sci_irq, 0);
      @(negedge clk);
      chk("R7 rst_req one cycle, resume held", {rst_req, resume_ind}, 2'b01);
      wr(16'h0002, 16'h0100);
      chk("R9 irq on button enable", sci_irq, 1);
      wr(16'h0002, 16'h0001);
      chk("R9 irq off with timer enable only", sci_irq, 0);
   endtask

   task automatic t_w1c;
      logic [DATA_W-1:0] v;
      wr(16'h0000, 16'h00FF);
      rd(16'h0000, v); chk("R3 zeros keep bits", v, 16'h8100);
      wr(16'h0000, 16'h0100);
      rd(16'h0000, v); chk("R3 clear button bit", v, 16'h8000);
      wr(16'h0002, 16'h8000);
      chk("R9 irq wake enabled", sci_irq, 1);
      wr(16'h0000, 16'h8000);
      rd(16'h0000, v); chk("R3 clear wake bit", v, 0);
      chk("R9 irq after clear", sci_irq, 0);
      chk("R7 resume still held", resume_ind, 1);
   endtask

   task automatic t_timer;
      logic [DATA_W-1:0] v;
      int c, d;
      wr(16'h0002, 16'h0001);
      wait_cyc(STEP);
      rd(16'h0000, v); chk("R10 no overflow at deadline count", v, 0);
      @(negedge clk);
      rd(16'h0000, v); chk("R10 overflow set", v, 16'h0001);
      chk("R9 irq on overflow", sci_irq, 1);
      wait_cyc(700);
      c = cyc;
      wr(16'h0000, 16'h0001);
      rd(16'h0000, v); chk("R3 R11 overflow cleared", v, 0);
      chk("R9 irq after overflow clear", sci_irq, 0);
      d = ((c + STEP) & ~(STEP - 1)) % (1 << TMR_W);
      wait_cyc(d);
      rd(16'h0000, v); chk("R11 quiet before rearmed deadline", v, 0);
      @(negedge clk);
      rd(16'h0000, v); chk("R11 overflow at rearmed deadline", v, 16'h0001);
      wait_cyc(1100);
      c = cyc;
      wr(16'h0000, 16'h0001);
      d = ((c + STEP) & ~(STEP - 1)) % (1 << TMR_W);
      wait_cyc(d);
      rd(16'h0000, v); chk("R11 quiet before second deadline", v, 0);
      @(negedge clk);
      rd(16'h0000, v); chk("R11 overflow at second deadline", v, 16'h0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fork
         begin
            t_reset;
            t_decode;
            t_control;
            t_poweroff;
            t_suspend;
            t_w1c;
            t_timer;
         end
         begin
            repeat (20000) @(posedge clk);
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule